// File: doc/BRIEF.md
# I2S Audio FIFO Port

This block is a memory-mapped stereo audio port. Software reaches it over a simple 32-bit register bus. Each sample pair is a single 32-bit word: the left channel sits in bits [31:16] and the right channel in bits [15:0]. Transmit words queue in one FIFO and received words queue in a second. The block is the bus master of the serial link. It produces the bit clock and the word clock from the audio master clock, which is also its system clock. It sends data on one serial line and captures data from another.

The frame follows standard I2S. The word clock is low while the left channel is on the line and high for the right channel. Each channel sends its 16 bits MSB first, starting one bit clock after the word-clock edge, and pads the rest of the slot with zeros. One bit clock lasts four master-clock cycles. Data changes on the falling edge of the bit clock and is sampled on the rising edge. The divide register sets the length of one channel half in master-clock cycles, so the frame rate is the master clock divided by twice that value.

The serial engine exchanges words with the two FIFOs over internal valid/ready handshakes. The register bus has no back-pressure: every access completes in the cycle it is presented. A data write into a full transmit FIFO is discarded and flagged, and a data read from an empty receive FIFO returns zero. The block also drives one level-sensitive interrupt, built from the FIFO level alerts, and one reset pin for the codec.

Top module: `i2s_fifo_port`

## Requirements
- R1: After reset, the registers read as follows. Control (word offset 0x00) reads 0x00002200, with both water levels equal to 2. Status (0x04) reads 0x15. Error (0x08) reads 0. Divide (0x0C) reads 0x080.
- R2: A write to transmit data (0x10) while the transmit FIFO holds DEPTH words is discarded and sets error bit 0. Status bit 3 reports the full transmit FIFO.
- R3: When a left channel starts with transmit enabled (control bit 0) and the transmit FIFO empty, the whole frame goes out as zeros and error bit 0 is set.
- R4: Error bits stay set until a write to the error register has a 1 in that bit position. Writing a 0 leaves the bit unchanged.
- R5: The serial output follows I2S framing. The word clock is low for left and changes only while the bit clock is low. The MSB of each channel appears in the second bit slot after the word-clock edge. Frames carry the transmit words in FIFO order.
- R6: With receive enabled (control bit 2), one word {left, right} is pushed at the end of each frame. If the receive FIFO is full at that moment, the word is dropped and error bit 1 is set.
- R7: Status bit 0 is 1 when the number of free transmit entries exceeds control[10:8]. Status bit 1 is 1 when the receive fill exceeds control[14:12]. Status bits 2, 3, 4 and 5 are transmit empty, transmit full, receive empty and receive full.
- R8: The interrupt output equals (status bit 0 AND control bit 1) OR (status bit 1 AND control bit 3).
- R9: Writing control with bit 16 set empties both FIFOs. The other control fields take the written value, and bit 16 reads back as 0.
- R10: The codec reset output follows control bit 17.
- R11: Each word-clock half lasts divide[9:0] master-clock cycles. Values below 8 are treated as 8.
- R12: A read of receive data (0x14) returns the oldest received word and removes it. A read while the receive FIFO is empty returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock, also the system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access strobe, completes in the same cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Level interrupt |
| codec_rst_o | output | 1 | Codec reset pin |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word clock, low for the left channel |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
Corrupt FIFO pointers or counts show up in the status register as soon as the next register read. They also show up within one frame as words that are reordered, repeated or missing on the line. A shifted bit counter or a swapped channel index corrupts every decoded sample in the first frame. A wrong half-length counter shows within one word-clock half as a changed gap between word-clock edges. A lost sticky error bit, or a misplaced underrun point, shows in the error register after the FIFO drains. An independent bench decoder of the serial line, together with a loopback into the receive path, catches both the transmit and the receive side.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned WORD_W   = 2 * SAMPLE_W;
  localparam int unsigned DIV_W    = 10;
  localparam int unsigned WL_W     = 3;

  // register word indices (byte offset / 4)
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_STAT = 1;
  localparam int unsigned IDX_ERR  = 2;
  localparam int unsigned IDX_DIV  = 3;
  localparam int unsigned IDX_TXD  = 4;
  localparam int unsigned IDX_RXD  = 5;

  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(128);
  localparam logic [WL_W-1:0]  WL_RESET  = WL_W'(2);

  typedef struct packed {
    logic            codec_rst;
    logic [WL_W-1:0] rx_wl;
    logic [WL_W-1:0] tx_wl;
    logic            rx_ie;
    logic            rx_en;
    logic            tx_ie;
    logic            tx_en;
  } port_ctrl_t;
endpackage

// File: rtl/i2s_sfifo.sv
module i2s_sfifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic [CW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    cnt;
  logic             push, pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = cnt < CW'(DEPTH);
  assign out_valid = cnt != '0;
  assign out_data  = mem[rd_ptr];
  assign level     = cnt;
  assign push      = in_valid && in_ready && !flush;
  assign pop       = out_valid && out_ready && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_ready && !flush) |=> level == $past(level));
  // R12
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid && !flush) |=> level == $past(level) - 1'b1);
endmodule

// File: rtl/i2s_serdes.sv
module i2s_serdes
  import i2s_port_pkg::*;
#(
  parameter int unsigned HALF_MIN = 8,
  localparam int unsigned IW = $clog2(WORD_W),
  localparam int unsigned BW = DIV_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_tx,
  input  logic              run_rx,
  input  logic [DIV_W-1:0]  half_len,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              tx_underrun,
  output logic              rx_overrun,
  output logic              sck_o,
  output logic              ws_o,
  output logic              sd_o,
  input  logic              sd_i
);
  logic                active, ws;
  logic [DIV_W-1:0]    pos, last;
  logic [WORD_W-1:0]   tx_word;
  logic [SAMPLE_W-1:0] rx_shift, rx_left;
  logic [BW-1:0]       slot;
  logic                run, fetch, end_half, data_slot;
  logic [IW-1:0]       bit_idx;

  assign run       = run_tx || run_rx;
  assign last      = ((half_len < DIV_W'(HALF_MIN)) ? DIV_W'(HALF_MIN) : half_len) - 1'b1;
  assign end_half  = active && (pos >= last);
  assign fetch     = run && (!active || (end_half && ws));
  assign slot      = pos[DIV_W-1:2];
  assign data_slot = active && (slot >= BW'(1)) && (slot <= BW'(SAMPLE_W));

  assign tx_ready    = fetch && run_tx;
  assign tx_underrun = tx_ready && !tx_valid;

  // bit position inside the packed word: left half reads the upper channel
  always_comb begin
    bit_idx = '0;
    if (data_slot)
      bit_idx = ws ? IW'(SAMPLE_W - 32'(slot)) : IW'(WORD_W - 32'(slot));
  end

  assign sd_o  = data_slot && tx_word[bit_idx];
  assign sck_o = active && pos[1];
  assign ws_o  = ws;

  assign rx_valid   = run_rx && end_half && ws;
  assign rx_data    = {rx_left, rx_shift};
  assign rx_overrun = rx_valid && !rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      ws       <= 1'b1;
      pos      <= '0;
      tx_word  <= '0;
      rx_shift <= '0;
      rx_left  <= '0;
    end else if (!run) begin
      active <= 1'b0;
      ws     <= 1'b1;
      pos    <= '0;
    end else begin
      if (fetch) tx_word <= (run_tx && tx_valid) ? tx_data : '0;
      if (!active) begin
        active <= 1'b1;
        ws     <= 1'b0;
        pos    <= '0;
      end else if (end_half) begin
        pos <= '0;
        ws  <= !ws;
        if (!ws) rx_left <= rx_shift;
      end else begin
        pos <= pos + 1'b1;
      end
      if (data_slot && pos[1:0] == 2'b10)
        rx_shift <= {rx_shift[SAMPLE_W-2:0], sd_i};
    end
  end

  // R5
  ws_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && ws_o != $past(ws_o)) |-> !sck_o);
  // R11
  ws_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && pos == '0) |-> ws_o != $past(ws_o));
endmodule

// File: rtl/i2s_fifo_port.sv
module i2s_fifo_port
  import i2s_port_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int XW = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              codec_rst_o,
  output logic              sck_o,
  output logic              ws_o,
  output logic              sd_o,
  input  logic              sd_i
);
  port_ctrl_t        ctrl;
  logic [DIV_W-1:0]  div_q;
  logic              err_tx, err_rx;
  logic [XW-1:0]     widx;
  logic              wr_ctrl, wr_err, wr_div, wr_txd, rd_rxd, flush;
  logic              tx_in_ready, tx_out_valid, tx_out_ready;
  logic [WORD_W-1:0] tx_out_data;
  logic              rx_in_valid, rx_in_ready, rx_out_valid;
  logic [WORD_W-1:0] rx_in_data, rx_out_data;
  logic [CW-1:0]     tx_level, rx_level;
  logic              tx_under, rx_over, tx_drop;
  logic              tx_alert, rx_alert;
  logic [5:0]        status;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign wr_ctrl = bus_req && bus_we && widx == XW'(IDX_CTRL);
  assign wr_err  = bus_req && bus_we && widx == XW'(IDX_ERR);
  assign wr_div  = bus_req && bus_we && widx == XW'(IDX_DIV);
  assign wr_txd  = bus_req && bus_we && widx == XW'(IDX_TXD);
  assign rd_rxd  = bus_req && !bus_we && widx == XW'(IDX_RXD);
  assign flush   = wr_ctrl && bus_wdata[16];
  assign tx_drop = wr_txd && !tx_in_ready;

  i2s_sfifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .flush,
    .in_valid(wr_txd), .in_ready(tx_in_ready), .in_data(bus_wdata),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level));

  i2s_sfifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .flush,
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rd_rxd), .out_data(rx_out_data),
    .level(rx_level));

  i2s_serdes u_ser (
    .clk, .rst_n,
    .run_tx(ctrl.tx_en), .run_rx(ctrl.rx_en), .half_len(div_q),
    .tx_valid(tx_out_valid), .tx_ready(tx_out_ready), .tx_data(tx_out_data),
    .rx_valid(rx_in_valid), .rx_ready(rx_in_ready), .rx_data(rx_in_data),
    .tx_underrun(tx_under), .rx_overrun(rx_over),
    .sck_o, .ws_o, .sd_o, .sd_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '{codec_rst: 1'b0, rx_wl: WL_RESET, tx_wl: WL_RESET,
                  rx_ie: 1'b0, rx_en: 1'b0, tx_ie: 1'b0, tx_en: 1'b0};
      div_q  <= DIV_RESET;
      err_tx <= 1'b0;
      err_rx <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl.codec_rst <= bus_wdata[17];
        ctrl.rx_wl     <= bus_wdata[14:12];
        ctrl.tx_wl     <= bus_wdata[10:8];
        ctrl.rx_ie     <= bus_wdata[3];
        ctrl.rx_en     <= bus_wdata[2];
        ctrl.tx_ie     <= bus_wdata[1];
        ctrl.tx_en     <= bus_wdata[0];
      end
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
      err_tx <= (err_tx && !(wr_err && bus_wdata[0])) || tx_drop || tx_under;
      err_rx <= (err_rx && !(wr_err && bus_wdata[1])) || rx_over;
    end
  end

  assign tx_alert = (CW'(DEPTH) - tx_level) > CW'(ctrl.tx_wl);
  assign rx_alert = rx_level > CW'(ctrl.rx_wl);
  assign status   = {rx_level == CW'(DEPTH), rx_level == '0,
                     tx_level == CW'(DEPTH), tx_level == '0, rx_alert, tx_alert};
  assign irq_o       = (tx_alert && ctrl.tx_ie) || (rx_alert && ctrl.rx_ie);
  assign codec_rst_o = ctrl.codec_rst;

  always_comb begin
    bus_rdata = '0;
    case (widx)
      XW'(IDX_CTRL): bus_rdata = {14'd0, ctrl.codec_rst, 2'b00, ctrl.rx_wl, 1'b0,
                                  ctrl.tx_wl, 4'd0, ctrl.rx_ie, ctrl.rx_en,
                                  ctrl.tx_ie, ctrl.tx_en};
      XW'(IDX_STAT): bus_rdata = {26'd0, status};
      XW'(IDX_ERR):  bus_rdata = {30'd0, err_rx, err_tx};
      XW'(IDX_DIV):  bus_rdata = {{(32-DIV_W){1'b0}}, div_q};
      XW'(IDX_RXD):  bus_rdata = rx_out_valid ? rx_out_data : '0;
      default:       bus_rdata = '0;
    endcase
  end

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_tx && !(wr_err && bus_wdata[0])) |=> err_tx);
  // R2
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && tx_level == CW'(DEPTH)) |=> err_tx);
  // R10
  codec_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> codec_rst_o == $past(bus_wdata[17]));
endmodule

// File: tb/sim_i2s_fifo_port.sv
module sim_i2s_fifo_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, crst, sck, ws, sdo, sdi;

  assign sdi = sdo;  // serial loopback

  i2s_fifo_port #(.DEPTH(DEPTH), .ADDR_W(8)) u0 (
    .clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .irq_o(irq), .codec_rst_o(crst), .sck_o(sck), .ws_o(ws), .sd_o(sdo), .sd_i(sdi));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] txq[$];
  logic [31:0] frames[$];
  int gaps[$];

  // independent serial-line decoder, sampled away from the active edge
  logic sck_prev = 1'b0, ws_prev = 1'b1, ws_at_rise = 1'b1, seen_left = 1'b0;
  logic [15:0] shreg = '0, left_hold = '0;
  int slot_n = 0, cyc = 0, last_edge = 0, ws_bad = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && ws != ws_prev) begin
      if (sck) ws_bad++;
      gaps.push_back(cyc - last_edge);
      last_edge = cyc;
    end
    ws_prev = ws;
    if (rst_n && sck && !sck_prev) begin
      if (ws != ws_at_rise) begin
        if (!ws_at_rise) begin left_hold = shreg; seen_left = 1'b1; end
        else if (seen_left) frames.push_back({left_hold, shreg});
        ws_at_rise = ws;
        slot_n = 0;
      end else slot_n++;
      if (slot_n >= 1 && slot_n <= 16) shreg = {shreg[14:0], sdo};
    end
    sck_prev = sck;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'(idx * 4); bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'(idx * 4) | 8'(idx & 3) ;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctrl(bit cr, int rxwl, int txwl, bit rie, bit ren, bit tie, bit ten);
    return (32'(cr) << 17) | (32'(rxwl & 7) << 12) | (32'(txwl & 7) << 8) |
           (32'(rie) << 3) | (32'(ren) << 2) | (32'(tie) << 1) | 32'(ten);
  endfunction

  function automatic logic [31:0] exp_stat(int txn, int rxn, int txwl, int rxwl);
    return 32'({rxn == DEPTH, rxn == 0, txn == DEPTH, txn == 0, rxn > rxwl, (DEPTH - txn) > txwl});
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] d, w;
    int seed = $urandom(32'h5eed_1234);
    int wl;
    bit ie;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 reset values
    rd(0, d); chk("R1 ctrl", d, 32'h0000_2200);
    rd(1, d); chk("R1 status", d, 32'h15);
    rd(2, d); chk("R1 error", d, 32'h0);
    rd(3, d); chk("R1 divide", d, 32'h080);
    chk("R8 irq idle", 32'(irq), 32'h0);

    // R10 codec reset pin
    wr(0, mk_ctrl(1, 2, 2, 0, 0, 0, 0));
    #1 chk("R10 pin high", 32'(crst), 32'h1);
    rd(0, d); chk("R10 readback", d, 32'h0002_2200);
    wr(0, mk_ctrl(0, 2, 2, 0, 0, 0, 0));
    #1 chk("R10 pin low", 32'(crst), 32'h0);

    // R7/R8 random fill and water levels, transmit idle
    for (int i = 0; i < 10; i++) begin
      int k = $urandom_range(0, 2);
      wl = $urandom_range(0, 7);
      ie = 1'($urandom_range(0, 1));
      wr(0, mk_ctrl(0, 2, wl, 0, 0, ie, 0));
      for (int j = 0; j < k && txq.size() < DEPTH; j++) begin
        w = $urandom; wr(4, w); txq.push_back(w);
      end
      rd(1, d); chk("R7 status tx alert", d, exp_stat(txq.size(), 0, wl, 2));
      chk("R8 irq tx", 32'(irq), 32'(ie && ((DEPTH - txq.size()) > wl)));
    end

    // R9 flush keeps fields
    wr(0, mk_ctrl(0, 5, 4, 0, 0, 0, 0) | 32'h0001_0000);
    rd(1, d); chk("R9 flushed status", d, exp_stat(0, 0, 4, 5));
    rd(0, d); chk("R9 fields kept", d, mk_ctrl(0, 5, 4, 0, 0, 0, 0));
    txq.delete();

    // R2 overflow drop
    for (int j = 0; j < DEPTH; j++) begin w = $urandom; wr(4, w); txq.push_back(w); end
    rd(2, d); chk("R2 no error before overflow", d, 32'h0);
    wr(4, 32'hDEAD_BEEF);
    rd(2, d); chk("R2 overflow flag", d, 32'h1);
    rd(1, d); chk("R2 full status", d, exp_stat(DEPTH, 0, 4, 5));

    // R4 write-one-to-clear
    wr(2, 32'h0);
    rd(2, d); chk("R4 zero write keeps", d, 32'h1);
    wr(2, 32'h1);
    rd(2, d); chk("R4 one write clears", d, 32'h0);

    // R11 divide then run loopback
    wr(3, 32'd72);
    rd(3, d); chk("R11 divide readback", d, 32'd72);
    wr(0, mk_ctrl(0, 3, 2, 1, 1, 0, 1));
    while (frames.size() < 10) @(posedge clk);
    wr(0, mk_ctrl(0, 3, 2, 1, 0, 0, 0));

    rd(2, d); chk("R3 R6 underrun and overrun", d, 32'h3);
    rd(1, d); chk("R6 rx full status", d, exp_stat(0, DEPTH, 2, 3));
    chk("R8 irq rx", 32'(irq), 32'h1);
    for (int j = 0; j < DEPTH; j++) chk("R5 decoded frame", frames[j], txq[j]);
    chk("R3 zero frame 9", frames[8], 32'h0);
    chk("R3 zero frame 10", frames[9], 32'h0);
    chk("R11 half length a", 32'(gaps[1]), 32'd72);
    chk("R11 half length b", 32'(gaps[2]), 32'd72);
    chk("R5 ws edges with sck low", 32'(ws_bad), 32'h0);

    for (int j = 0; j < DEPTH; j++) begin
      rd(5, d); chk("R12 rx word order", d, txq[j]);
    end
    rd(1, d); chk("R12 rx empty status", d, exp_stat(0, 0, 2, 3));
    chk("R8 irq cleared", 32'(irq), 32'h0);
    rd(5, d); chk("R12 empty read", d, 32'h0);

    if (seed == 0) $display("seed zero");
    finish_run();
  end
endmodule